// File: doc/BRIEF.md
# DDR SDRAM Bank Timing Checker

This block sits on the controller side of a four-bank DDR SDRAM rank and watches the decoded command stream, one command per clock. For every command it decides whether the command keeps the minimum command spacing of the memory. The checks cover the same bank, other banks, refresh, mode-register writes and read/write bus turnaround, and several of the limits depend on the programmed burst length. It keeps, for each bank, an open/closed flag and counters of the cycles since that bank's last activate, read, write and close. It also keeps rank-wide counters for the latest activate, refresh, mode-register write, read and write.

A command is either accepted, so that it updates the tracked state, or refused with a violation code, so that it changes nothing. The verdict is registered and appears on the outputs in the cycle after the command is presented. Every cycle limit is a module parameter. The limits are computed by ceiling division of a nanosecond figure by the clock period, so the block can be retargeted to another clock rate by changing the parameters.

Top module: `ddr_cmd_timing_check`

## Requirements
- R1: After reset all banks are closed, every spacing counter counts as fully elapsed, and the outputs `cmd_ok`, `viol` and `viol_code` are 0. A first ACTIVE is accepted at once.
- R2: Command encoding on `cmd`: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 AUTO REFRESH, 6 MODE REGISTER SET. The verdict for a command sampled at a clock edge is shown after that edge: `cmd_ok`=1 if it was accepted, or `viol`=1 with a nonzero `viol_code` if it was refused. A NOP gives all zeros.
- R3: Code 3 (bank state) is raised for READ or WRITE to a closed bank, for ACTIVE to an open bank, and for AUTO REFRESH or MODE REGISTER SET while any bank is open. `bank` is BA1:BA0 with `bank[0]` = BA0.
- R4: Code 4 is raised for READ or WRITE issued fewer than tRCD (default 3) cycles after that bank's ACTIVE.
- R5: PRECHARGE with `a10`=0 closes only the addressed bank. With `a10`=1 it closes every open bank. PRECHARGE of a closed bank has no effect. Code 5 is raised for ACTIVE to a bank fewer than tRP (default 3) cycles after it closed, and for AUTO REFRESH while any bank's close wait is still running.
- R6: Code 6 is raised for ACTIVE to a bank, or AUTO REFRESH, fewer than tRC (default 11) cycles after an ACTIVE to that bank (for refresh: to any bank). Code 7 is raised for ACTIVE fewer than tRRD (default 2) cycles after the previous accepted ACTIVE.
- R7: Code 8 is raised for PRECHARGE that would close a bank fewer than tRAS (default 8) cycles after its ACTIVE.
- R8: `bl_sel` 0, 1, 2 selects burst length 2, 4, 8 (3 is treated as 8). Let H be half the burst length. Code 9 is raised for PRECHARGE that would close a bank fewer than 4+H cycles after a WRITE to it. Code 10 is raised when that distance after a READ to it is below H.
- R9: Code 11 is raised for READ fewer than 2+H cycles after any WRITE. Code 12 is raised for WRITE fewer than 3+H cycles after any READ.
- R10: READ or WRITE with `a10`=1 closes its bank once accepted. After such a WRITE, ACTIVE to that bank needs tDAL = ceil(tWR/tCK)+ceil(tRP/tCK) (default 6) cycles. After such a READ it needs H+tRP cycles. An early ACTIVE gives code 5.
- R11: Code 2 is raised for ACTIVE or AUTO REFRESH fewer than tRFC (default 14) cycles after an accepted AUTO REFRESH.
- R12: Code 1 is raised for any command fewer than tMRD (default 2) cycles after an accepted MODE REGISTER SET.
- R13: When several rules fail, the lowest-numbered code is reported. A refused command updates no bank or rank state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Decoded command (encoding in R2) |
| bank | input | 2 | Bank address, bit 0 = BA0 |
| a10 | input | 1 | All-bank precharge / auto-precharge select |
| bl_sel | input | 2 | Burst length select (encoding in R8) |
| cmd_ok | output | 1 | Previous command was accepted |
| viol | output | 1 | Previous command was refused |
| viol_code | output | 4 | Code of the rule that refused it, 0 if none |

## Verification
A wrong open/closed flag is visible at the ports one cycle after the next command to that bank: a read is wrongly refused with code 3, or a second activate is wrongly accepted. A counter that starts or saturates wrongly moves a pass/fail boundary by a cycle. For that reason each spacing rule is probed one cycle short of its limit and again exactly at it, so that an off-by-one shows up as a wrong verdict on the very next command. State that a refused command leaks into the tracker shows up on a later command whose spacing is measured from the last accepted event.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } ddr_cmd_e;

  localparam int NUM_RULES = 12;

  // ceiling division of a picosecond figure by the clock period
  function automatic int ps_to_clk(input int t_ps, input int tck_ps);
    return (t_ps + tck_ps - 1) / tck_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
  import ddr_chk_pkg::*;
#(
  parameter int CW    = 4,
  parameter int MAXV  = 14,
  parameter int T_RP  = 3,
  parameter int T_DAL = 6,
  parameter int T_RCD = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [2:0]    cmd,
  input  logic          hit,
  input  logic          a10,
  input  logic [CW-1:0] half_bl,
  output logic          open_o,
  output logic [CW-1:0] act_cnt,
  output logic [CW-1:0] rd_cnt,
  output logic [CW-1:0] wr_cnt,
  output logic [CW-1:0] cls_cnt,
  output logic [CW-1:0] cls_need
);

  localparam logic [CW-1:0] SAT  = CW'(MAXV);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] RP_C = CW'(T_RP);

  logic          open_q, open_n;
  logic [CW-1:0] act_q, act_n, rd_q, rd_n, wr_q, wr_n;
  logic [CW-1:0] cls_q, cls_n, need_q, need_n;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return (v == SAT) ? v : v + ONE;
  endfunction

  always_comb begin
    open_n = open_q;
    act_n  = bump(act_q);
    rd_n   = bump(rd_q);
    wr_n   = bump(wr_q);
    cls_n  = bump(cls_q);
    need_n = need_q;
    if (acc) begin
      case (ddr_cmd_e'(cmd))
        CMD_ACT: if (hit) begin
          open_n = 1'b1;
          act_n  = ONE;
        end
        CMD_RD: if (hit) begin
          rd_n = ONE;
          if (a10) begin
            open_n = 1'b0;
            cls_n  = ONE;
            need_n = half_bl + RP_C;
          end
        end
        CMD_WR: if (hit) begin
          wr_n = ONE;
          if (a10) begin
            open_n = 1'b0;
            cls_n  = ONE;
            need_n = CW'(T_DAL);
          end
        end
        CMD_PRE: if ((hit || a10) && open_q) begin
          open_n = 1'b0;
          cls_n  = ONE;
          need_n = RP_C;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      act_q  <= SAT;
      rd_q   <= SAT;
      wr_q   <= SAT;
      cls_q  <= SAT;
      need_q <= '0;
    end else begin
      open_q <= open_n;
      act_q  <= act_n;
      rd_q   <= rd_n;
      wr_q   <= wr_n;
      cls_q  <= cls_n;
      need_q <= need_n;
    end
  end

  assign open_o   = open_q;
  assign act_cnt  = act_q;
  assign rd_cnt   = rd_q;
  assign wr_cnt   = wr_q;
  assign cls_cnt  = cls_q;
  assign cls_need = need_q;

  // R3
  open_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(acc && hit && cmd == CMD_ACT));

  // R10
  open_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open_q) |-> $past(acc && (cmd == CMD_PRE ||
                             (hit && a10 && (cmd == CMD_RD || cmd == CMD_WR)))));

  // R4
  col_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hit && (cmd == CMD_RD || cmd == CMD_WR)) |-> (open_q && act_q >= CW'(T_RCD)));

endmodule

// File: rtl/ddr_bus_track.sv
module ddr_bus_track
  import ddr_chk_pkg::*;
#(
  parameter int CW    = 4,
  parameter int MAXV  = 14,
  parameter int T_RFC = 14,
  parameter int T_MRD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [2:0]    cmd,
  output logic [CW-1:0] gact_cnt,
  output logic [CW-1:0] ref_cnt,
  output logic [CW-1:0] mrs_cnt,
  output logic [CW-1:0] grd_cnt,
  output logic [CW-1:0] gwr_cnt
);

  localparam logic [CW-1:0] SAT = CW'(MAXV);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] act_q, act_n, ref_q, ref_n, mrs_q, mrs_n, rd_q, rd_n, wr_q, wr_n;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return (v == SAT) ? v : v + ONE;
  endfunction

  always_comb begin
    act_n = bump(act_q);
    ref_n = bump(ref_q);
    mrs_n = bump(mrs_q);
    rd_n  = bump(rd_q);
    wr_n  = bump(wr_q);
    if (acc) begin
      case (ddr_cmd_e'(cmd))
        CMD_ACT: act_n = ONE;
        CMD_REF: ref_n = ONE;
        CMD_MRS: mrs_n = ONE;
        CMD_RD:  rd_n  = ONE;
        CMD_WR:  wr_n  = ONE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= SAT;
      ref_q <= SAT;
      mrs_q <= SAT;
      rd_q  <= SAT;
      wr_q  <= SAT;
    end else begin
      act_q <= act_n;
      ref_q <= ref_n;
      mrs_q <= mrs_n;
      rd_q  <= rd_n;
      wr_q  <= wr_n;
    end
  end

  assign gact_cnt = act_q;
  assign ref_cnt  = ref_q;
  assign mrs_cnt  = mrs_q;
  assign grd_cnt  = rd_q;
  assign gwr_cnt  = wr_q;

  // R11
  rfc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd == CMD_ACT || cmd == CMD_REF)) |-> (ref_q >= CW'(T_RFC)));

  // R12
  mrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd != CMD_NOP) |-> (mrs_q >= CW'(T_MRD)));

endmodule

// File: rtl/ddr_rule_eval.sv
module ddr_rule_eval
  import ddr_chk_pkg::*;
#(
  parameter int NB    = 4,
  parameter int BW    = 2,
  parameter int CW    = 4,
  parameter int T_RCD = 3,
  parameter int T_RRD = 2,
  parameter int T_RAS = 8,
  parameter int T_RC  = 11,
  parameter int T_RFC = 14,
  parameter int T_MRD = 2
) (
  input  logic [2:0]              cmd,
  input  logic [BW-1:0]           bank,
  input  logic                    a10,
  input  logic [CW-1:0]           half_bl,
  input  logic [NB-1:0]           open_v,
  input  logic [NB-1:0][CW-1:0]   act_cnt,
  input  logic [NB-1:0][CW-1:0]   rd_cnt,
  input  logic [NB-1:0][CW-1:0]   wr_cnt,
  input  logic [NB-1:0][CW-1:0]   cls_cnt,
  input  logic [NB-1:0][CW-1:0]   cls_need,
  input  logic [CW-1:0]           gact_cnt,
  input  logic [CW-1:0]           ref_cnt,
  input  logic [CW-1:0]           mrs_cnt,
  input  logic [CW-1:0]           grd_cnt,
  input  logic [CW-1:0]           gwr_cnt,
  output logic                    accept,
  output logic [3:0]              code
);

  localparam logic [CW-1:0] RCD_C = CW'(T_RCD);
  localparam logic [CW-1:0] RRD_C = CW'(T_RRD);
  localparam logic [CW-1:0] RAS_C = CW'(T_RAS);
  localparam logic [CW-1:0] RC_C  = CW'(T_RC);
  localparam logic [CW-1:0] RFC_C = CW'(T_RFC);
  localparam logic [CW-1:0] MRD_C = CW'(T_MRD);

  ddr_cmd_e c;
  logic [NUM_RULES-1:0] fail;   // bit k -> code k+1
  logic is_act, is_col, is_pre, is_ref, is_mrs, any_open;
  logic [CW-1:0] wr_pre_lim, wr_rd_lim, rd_wr_lim;

  assign c      = ddr_cmd_e'(cmd);
  assign is_act = (c == CMD_ACT);
  assign is_col = (c == CMD_RD) || (c == CMD_WR);
  assign is_pre = (c == CMD_PRE);
  assign is_ref = (c == CMD_REF);
  assign is_mrs = (c == CMD_MRS);
  assign any_open   = |open_v;
  assign wr_pre_lim = CW'(4) + half_bl;
  assign wr_rd_lim  = CW'(2) + half_bl;
  assign rd_wr_lim  = CW'(3) + half_bl;

  always_comb begin
    fail = '0;
    if (c != CMD_NOP) begin
      fail[0] = (mrs_cnt < MRD_C);
      fail[1] = (is_act || is_ref) && (ref_cnt < RFC_C);
      fail[2] = (is_col && !open_v[bank]) || (is_act && open_v[bank]) ||
                ((is_ref || is_mrs) && any_open);
      fail[3] = is_col && (act_cnt[bank] < RCD_C);
      fail[4] = is_act && (cls_cnt[bank] < cls_need[bank]);
      fail[5] = is_act && (act_cnt[bank] < RC_C);
      fail[6] = is_act && (gact_cnt < RRD_C);
      fail[10] = (c == CMD_RD) && (gwr_cnt < wr_rd_lim);
      fail[11] = (c == CMD_WR) && (grd_cnt < rd_wr_lim);
      for (int i = 0; i < NB; i++) begin
        if (is_ref) begin
          if (cls_cnt[i] < cls_need[i]) fail[4] = 1'b1;
          if (act_cnt[i] < RC_C)        fail[5] = 1'b1;
        end
        if (is_pre && open_v[i] && (a10 || bank == BW'(i))) begin
          if (act_cnt[i] < RAS_C)      fail[7] = 1'b1;
          if (wr_cnt[i]  < wr_pre_lim) fail[8] = 1'b1;
          if (rd_cnt[i]  < half_bl)    fail[9] = 1'b1;
        end
      end
    end
  end

  // lowest-numbered failing rule wins
  always_comb begin
    code = 4'd0;
    for (int k = NUM_RULES - 1; k >= 0; k--) begin
      if (fail[k]) code = 4'(k + 1);
    end
  end

  assign accept = (c != CMD_NOP) && (fail == '0);

endmodule

// File: rtl/ddr_cmd_timing_check.sv
module ddr_cmd_timing_check
  import ddr_chk_pkg::*;
#(
  parameter int NBANK   = 4,
  parameter int TCK_PS  = 5000,
  parameter int TRCD_PS = 15000,
  parameter int TRP_PS  = 15000,
  parameter int TRRD_PS = 10000,
  parameter int TRAS_PS = 40000,
  parameter int TRC_PS  = 55000,
  parameter int TRFC_PS = 70000,
  parameter int TWR_PS  = 15000,
  parameter int TMRD_CK = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cmd,
  input  logic [1:0] bank,
  input  logic       a10,
  input  logic [1:0] bl_sel,
  output logic       cmd_ok,
  output logic       viol,
  output logic [3:0] viol_code
);

  localparam int BW    = $clog2(NBANK);
  localparam int T_RCD = ps_to_clk(TRCD_PS, TCK_PS);
  localparam int T_RP  = ps_to_clk(TRP_PS, TCK_PS);
  localparam int T_RRD = ps_to_clk(TRRD_PS, TCK_PS);
  localparam int T_RAS = ps_to_clk(TRAS_PS, TCK_PS);
  localparam int T_RC  = ps_to_clk(TRC_PS, TCK_PS);
  localparam int T_RFC = ps_to_clk(TRFC_PS, TCK_PS);
  localparam int T_WR  = ps_to_clk(TWR_PS, TCK_PS);
  localparam int T_DAL = T_WR + T_RP;
  localparam int T_MRD = TMRD_CK;
  localparam int MAXV  = imax(imax(imax(T_RC, T_RFC), imax(T_DAL, T_RAS)),
                              imax(imax(8, T_RP + 4), imax(imax(T_MRD, T_RCD), T_RRD)));
  localparam int CW    = $clog2(MAXV + 1);

  logic [CW-1:0] half_bl;
  always_comb begin
    case (bl_sel)
      2'd0:    half_bl = CW'(1);
      2'd1:    half_bl = CW'(2);
      default: half_bl = CW'(4);
    endcase
  end

  logic                  accept;
  logic [3:0]            code;
  logic [NBANK-1:0]      open_v;
  logic [NBANK-1:0][CW-1:0] act_cnt, rd_cnt, wr_cnt, cls_cnt, cls_need;
  logic [CW-1:0]         gact_cnt, ref_cnt, mrs_cnt, grd_cnt, gwr_cnt;

  for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
    ddr_bank_track #(
      .CW(CW), .MAXV(MAXV), .T_RP(T_RP), .T_DAL(T_DAL), .T_RCD(T_RCD)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (accept),
      .cmd      (cmd),
      .hit      (bank[BW-1:0] == BW'(gi)),
      .a10      (a10),
      .half_bl  (half_bl),
      .open_o   (open_v[gi]),
      .act_cnt  (act_cnt[gi]),
      .rd_cnt   (rd_cnt[gi]),
      .wr_cnt   (wr_cnt[gi]),
      .cls_cnt  (cls_cnt[gi]),
      .cls_need (cls_need[gi])
    );
  end

  ddr_bus_track #(
    .CW(CW), .MAXV(MAXV), .T_RFC(T_RFC), .T_MRD(T_MRD)
  ) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (accept),
    .cmd      (cmd),
    .gact_cnt (gact_cnt),
    .ref_cnt  (ref_cnt),
    .mrs_cnt  (mrs_cnt),
    .grd_cnt  (grd_cnt),
    .gwr_cnt  (gwr_cnt)
  );

  ddr_rule_eval #(
    .NB(NBANK), .BW(BW), .CW(CW), .T_RCD(T_RCD), .T_RRD(T_RRD),
    .T_RAS(T_RAS), .T_RC(T_RC), .T_RFC(T_RFC), .T_MRD(T_MRD)
  ) u_eval (
    .cmd      (cmd),
    .bank     (bank[BW-1:0]),
    .a10      (a10),
    .half_bl  (half_bl),
    .open_v   (open_v),
    .act_cnt  (act_cnt),
    .rd_cnt   (rd_cnt),
    .wr_cnt   (wr_cnt),
    .cls_cnt  (cls_cnt),
    .cls_need (cls_need),
    .gact_cnt (gact_cnt),
    .ref_cnt  (ref_cnt),
    .mrs_cnt  (mrs_cnt),
    .grd_cnt  (grd_cnt),
    .gwr_cnt  (gwr_cnt),
    .accept   (accept),
    .code     (code)
  );

  logic       ok_q, ok_n, viol_q, viol_n;
  logic [3:0] code_q, code_n;

  always_comb begin
    ok_n   = accept;
    viol_n = (code != 4'd0);
    code_n = code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q   <= 1'b0;
      viol_q <= 1'b0;
      code_q <= 4'd0;
    end else begin
      ok_q   <= ok_n;
      viol_q <= viol_n;
      code_q <= code_n;
    end
  end

  assign cmd_ok    = ok_q;
  assign viol      = viol_q;
  assign viol_code = code_q;

  // R2
  nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd) == CMD_NOP) |-> (!cmd_ok && !viol));

  // R13
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ok |-> (viol_code == 4'd0));

  // R3
  rd_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && $past(cmd) == CMD_RD) |-> $past(open_v[bank[BW-1:0]]));

endmodule

// File: tb/ddr_cmd_timing_check_test.sv
module ddr_cmd_timing_check_test;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, REF = 3'd5, MRS = 3'd6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd = NOP;
  logic [1:0] bank = 2'd0;
  logic       a10 = 1'b0;
  logic [1:0] bl_sel = 2'd1;
  logic       cmd_ok, viol;
  logic [3:0] viol_code;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ddr_cmd_timing_check uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .a10(a10),
    .bl_sel(bl_sel), .cmd_ok(cmd_ok), .viol(viol), .viol_code(viol_code)
  );

  task automatic verdict(input string tag, input logic eok, input logic [3:0] ecode);
    checks++;
    if (cmd_ok !== eok || viol !== (ecode != 0) || viol_code !== ecode) begin
      errors++;
      $display("FAIL %s: ok=%0b viol=%0b code=%0d, expected ok=%0b viol=%0b code=%0d",
               tag, cmd_ok, viol, viol_code, eok, (ecode != 0), ecode);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd = NOP;
    a10 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    verdict("R1 reset outputs", 1'b0, 4'd0);
  endtask

  task automatic send(input logic [2:0] c, input logic [1:0] b, input logic a,
                      input logic eok, input logic [3:0] ecode, input string tag);
    @(negedge clk);
    cmd = c;
    bank = b;
    a10 = a;
    @(posedge clk);
    #1;
    verdict(tag, eok, ecode);
    cmd = NOP;
    a10 = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset_state();
    do_reset();
    idle(2);
    verdict("R2 NOP gives no verdict", 1'b0, 4'd0);
    send(RD,  2'd0, 1'b0, 1'b0, 4'd3, "R3 read of closed bank after reset");
    send(ACT, 2'd0, 1'b0, 1'b1, 4'd0, "R1 first activate accepted");
  endtask

  task automatic t_rcd();
    bl_sel = 2'd1;
    do_reset();
    send(ACT, 2'd1, 1'b0, 1'b1, 4'd0, "R4 activate bank1");
    idle(1);
    send(RD,  2'd1, 1'b0, 1'b0, 4'd4, "R4 read one short of tRCD");
    send(RD,  2'd1, 1'b0, 1'b1, 4'd0, "R4 read at tRCD");
    send(ACT, 2'd1, 1'b0, 1'b0, 4'd3, "R3 activate of open bank");
  endtask

  task automatic t_rrd_ras_rp();
    bl_sel = 2'd1;
    do_reset();
    send(ACT, 2'd0, 1'b0, 1'b1, 4'd0, "R6 activate bank0");
    send(ACT, 2'd2, 1'b0, 1'b0, 4'd7, "R6 activate inside tRRD");
    send(ACT, 2'd2, 1'b0, 1'b1, 4'd0, "R13 refused activate left tRRD origin unchanged");
    send(PRE, 2'd2, 1'b0, 1'b0, 4'd8, "R7 precharge inside tRAS");
    idle(4);
    send(PRE, 2'd0, 1'b0, 1'b1, 4'd0, "R7 precharge at tRAS");
    send(ACT, 2'd0, 1'b0, 1'b0, 4'd5, "R5 activate inside tRP");
    idle(1);
    send(ACT, 2'd0, 1'b0, 1'b1, 4'd0, "R5 activate at tRP");
  endtask

  task automatic t_pre_all();
    bl_sel = 2'd1;
    do_reset();
    send(ACT, 2'd0, 1'b0, 1'b1, 4'd0, "R5 activate bank0");
    idle(1);
    send(ACT, 2'd1, 1'b0, 1'b1, 4'd0, "R5 activate bank1");
    idle(1);
    send(ACT, 2'd3, 1'b0, 1'b1, 4'd0, "R5 activate bank3");
    idle(7);
    send(PRE, 2'd0, 1'b0, 1'b1, 4'd0, "R5 single-bank precharge");
    send(RD,  2'd1, 1'b0, 1'b1, 4'd0, "R5 other bank still open");
    send(PRE, 2'd0, 1'b1, 1'b0, 4'd10, "R8 all-bank precharge right after read");
    send(PRE, 2'd0, 1'b1, 1'b1, 4'd0, "R5 all-bank precharge");
    send(RD,  2'd3, 1'b0, 1'b0, 4'd3, "R5 bank3 closed by all-bank precharge");
    send(ACT, 2'd1, 1'b0, 1'b0, 4'd5, "R5 bank1 close wait running");
    send(ACT, 2'd1, 1'b0, 1'b1, 4'd0, "R5 bank1 reopen at tRP");
  endtask

  task automatic t_turnaround();
    bl_sel = 2'd2;
    do_reset();
    send(ACT, 2'd0, 1'b0, 1'b1, 4'd0, "R9 activate");
    idle(2);
    send(WR,  2'd0, 1'b0, 1'b1, 4'd0, "R9 write");
    send(RD,  2'd0, 1'b0, 1'b0, 4'd11, "R9 read right after write BL8");
    idle(4);
    send(RD,  2'd0, 1'b0, 1'b1, 4'd0, "R9 read at 2+BL/2");
    send(WR,  2'd0, 1'b0, 1'b0, 4'd12, "R9 write right after read BL8");
    idle(5);
    send(WR,  2'd0, 1'b0, 1'b1, 4'd0, "R9 write at 3+BL/2");
    send(PRE, 2'd0, 1'b0, 1'b0, 4'd9, "R8 precharge right after write");
    idle(6);
    send(PRE, 2'd0, 1'b0, 1'b1, 4'd0, "R8 precharge at 4+BL/2");
    bl_sel = 2'd0;
    do_reset();
    send(ACT, 2'd1, 1'b0, 1'b1, 4'd0, "R8 activate BL2");
    idle(2);
    send(WR,  2'd1, 1'b0, 1'b1, 4'd0, "R8 write BL2");
    idle(2);
    send(RD,  2'd1, 1'b0, 1'b1, 4'd0, "R8 BL2 write-to-read of 3 accepted");
  endtask

  task automatic t_auto_pre();
    bl_sel = 2'd1;
    do_reset();
    send(ACT, 2'd2, 1'b0, 1'b1, 4'd0, "R10 activate bank2");
    idle(2);
    send(WR,  2'd2, 1'b1, 1'b1, 4'd0, "R10 write with auto-precharge");
    send(RD,  2'd2, 1'b0, 1'b0, 4'd3, "R10 bank closed by auto-precharge");
    idle(3);
    send(ACT, 2'd2, 1'b0, 1'b0, 4'd5, "R10 activate inside tDAL");
    send(ACT, 2'd2, 1'b0, 1'b0, 4'd6, "R6 activate at tDAL but inside tRC");
    idle(1);
    send(ACT, 2'd2, 1'b0, 1'b1, 4'd0, "R6 activate at tRC");
    idle(2);
    send(RD,  2'd2, 1'b1, 1'b1, 4'd0, "R10 read with auto-precharge");
    idle(3);
    send(ACT, 2'd2, 1'b0, 1'b0, 4'd5, "R10 activate inside BL/2+tRP");
    send(ACT, 2'd2, 1'b0, 1'b0, 4'd6, "R6 activate inside tRC after auto read");
    idle(2);
    send(ACT, 2'd2, 1'b0, 1'b1, 4'd0, "R6 activate at tRC after auto read");
  endtask

  task automatic t_refresh();
    bl_sel = 2'd1;
    do_reset();
    send(REF, 2'd0, 1'b0, 1'b1, 4'd0, "R11 refresh");
    send(REF, 2'd0, 1'b0, 1'b0, 4'd2, "R11 refresh inside tRFC");
    idle(11);
    send(ACT, 2'd0, 1'b0, 1'b0, 4'd2, "R11 activate one short of tRFC");
    send(ACT, 2'd0, 1'b0, 1'b1, 4'd0, "R11 activate at tRFC");
    send(REF, 2'd0, 1'b0, 1'b0, 4'd3, "R3 refresh with open bank");
    idle(6);
    send(PRE, 2'd0, 1'b0, 1'b1, 4'd0, "R11 precharge before refresh");
    send(REF, 2'd0, 1'b0, 1'b0, 4'd5, "R5 refresh while close wait runs");
    idle(1);
    send(REF, 2'd0, 1'b0, 1'b1, 4'd0, "R11 refresh after waits");
  endtask

  task automatic t_mrs();
    bl_sel = 2'd1;
    do_reset();
    send(MRS, 2'd0, 1'b0, 1'b1, 4'd0, "R12 mode register set");
    send(RD,  2'd1, 1'b0, 1'b0, 4'd1, "R13 tMRD reported before closed-bank");
    send(ACT, 2'd1, 1'b0, 1'b1, 4'd0, "R12 activate at tMRD");
    idle(2);
    send(MRS, 2'd0, 1'b0, 1'b0, 4'd3, "R3 mode set with open bank");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_rcd();
    t_rrd_ras_rp();
    t_pre_all();
    t_turnaround();
    t_auto_pre();
    t_refresh();
    t_mrs();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule